// File: doc/BRIEF.md
# Configuration Controller Register File

This block is the memory-mapped register set of a controller that loads a bitstream into programmable logic. Software reaches it over a plain 32-bit bus: a one-cycle write strobe with an address and data, and a read path that returns the addressed register in the same cycle. It holds the control word, the interrupt status and mask, a status word, four DMA descriptor words, a miscellaneous control word, and the lock and unlock registers.

Raw event pulses from the configuration fabric and the DMA engine enter on `evt_in`. They are folded into sticky interrupt status bits that software acknowledges by writing ones. A single `irq` output is high while any unmasked status bit is set. The control word is write-protected until software writes a 32-bit key to the unlock register. A modelled fabric answers the active-low program-reset control bit by moving the init status bit after a fixed delay. Two small state machines hold the rest of the behaviour. The lock machine has states LK_LOCKED and LK_OPEN. Its transitions are LK_LOCKED to LK_OPEN on a key write, and LK_OPEN to LK_LOCKED on a non-zero write to the lock register. The init machine has states IN_HIGH, IN_FALL, IN_LOW and IN_RISE. Its transitions are IN_HIGH to IN_FALL when the program bit is low, IN_FALL to IN_LOW when the delay expires, IN_FALL back to IN_HIGH when the program bit returns high early, IN_LOW to IN_RISE when the program bit is high, IN_RISE to IN_HIGH when the delay expires, and IN_RISE back to IN_LOW when the program bit drops early.

Top module: `cfgctl_regfile`

## Requirements
- R1: After reset the block is locked and the lock register reads 1. The control register reads 0x40000000, the interrupt mask reads 0xFFFFFFFF, the interrupt status reads 0, status bit 4 (init) reads 1 and `irq` is low.
- R2: The descriptor words at offsets 0x18 (source address), 0x1C (destination address), 0x20 (source length) and 0x24 (destination length) store all 32 written bits and read them back.
- R3: While locked, writes to the control register at 0x00 change nothing. Writing exactly 0x757BDF0D to 0x34 unlocks the block, and any other value there leaves it locked. Bit 0 of the lock register at 0x04 reads 1 when locked and 0 when unlocked.
- R4: A non-zero write to the lock register re-locks the block. A zero write leaves the lock state unchanged.
- R5: The control register keeps only bit 30 (program-reset, active low), bit 27 (partial reconfiguration) and bit 26 (configuration port enable). All other bits read 0.
- R6: Status bit 4 at 0x14 falls on the (INIT_DELAY+1)-th rising clock edge after the edge that writes control bit 30 to 0, provided bit 30 stays 0. It rises on the same count after bit 30 is written back to 1.
- R7: If control bit 30 returns to its previous level before the delay has elapsed, status bit 4 does not change, and the delay count restarts on the next change.
- R8: Status bit 31 follows the `dma_q_full` input in the same cycle. Status bits other than 31 and 4 read 0.
- R9: A 1 on an `evt_in` bit sets the matching interrupt status bit (0x0C) at the next edge if that bit is in 0xF8F7F87F. Other bits never set. Bit 13 marks DMA done, bit 12 marks DMA and configuration done, and bit 2 marks the fabric programmed. Writing 1 to a status bit clears it and writing 0 leaves it set. An event on the same edge as a clearing write wins.
- R10: `irq` is high exactly while some interrupt status bit is set and its mask bit at 0x10 is 0. The mask stores all 32 bits.
- R11: The miscellaneous control register at 0x80 keeps only bit 4 (configuration port loopback). Other bits read 0.
- R12: Reads of the unlock register and of any offset not listed above return 0. Writes to unlisted offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| evt_in | input | 32 | Raw event pulses, one per interrupt source |
| dma_q_full | input | 1 | DMA command queue full indication |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions assume that every input is synchronous to `clk` and holds steady around the rising edge. They also assume that a write strobe carries one address, so a key write and a control write can never land on the same edge. The bench drives every input on the falling edge and raises the write strobe for exactly one cycle per access, so both conditions always hold. The event pulses may overlap writes to the interrupt status register, which covers the set-over-clear case. The bench never depends on the order in which the two collide.

// File: rtl/cfgctl_pkg.sv
package cfgctl_pkg;

    localparam int DW = 32;

    // register offsets (byte addresses)
    localparam logic [7:0] OFF_CTRL   = 8'h00;
    localparam logic [7:0] OFF_LOCK   = 8'h04;
    localparam logic [7:0] OFF_ISTS   = 8'h0C;
    localparam logic [7:0] OFF_IMASK  = 8'h10;
    localparam logic [7:0] OFF_STATUS = 8'h14;
    localparam logic [7:0] OFF_UNLOCK = 8'h34;
    localparam logic [7:0] OFF_MISC   = 8'h80;

    // descriptor words: source addr, destination addr, source len, destination len
    localparam int DESC_N = 4;
    localparam logic [7:0] OFF_DESC [DESC_N] = '{8'h18, 8'h1C, 8'h20, 8'h24};

    localparam logic [DW-1:0] UNLOCK_KEY = 32'h757B_DF0D;

    // control word fields
    localparam int BIT_PROG = 30;
    localparam int BIT_PR   = 27;
    localparam int BIT_PORT = 26;
    localparam logic [DW-1:0] CTRL_KEEP  = (32'd1 << BIT_PROG) | (32'd1 << BIT_PR) | (32'd1 << BIT_PORT);
    localparam logic [DW-1:0] CTRL_RESET = 32'd1 << BIT_PROG;

    // status word fields
    localparam int BIT_QFULL = 31;
    localparam int BIT_INIT  = 4;

    // misc control word
    localparam int BIT_LOOP = 4;
    localparam logic [DW-1:0] MISC_KEEP = 32'd1 << BIT_LOOP;

    // interrupt sources that exist
    localparam logic [DW-1:0] ISTS_IMPL = 32'hF8F7_F87F;

    typedef enum logic {
        LK_LOCKED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_st_e;

    typedef enum logic [1:0] {
        IN_HIGH = 2'd0,
        IN_FALL = 2'd1,
        IN_LOW  = 2'd2,
        IN_RISE = 2'd3
    } init_st_e;

endpackage

// File: rtl/cfgctl_lock_fsm.sv
module cfgctl_lock_fsm
    import cfgctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_wr,     // correct key written to the unlock register
    input  logic relock_wr,  // non-zero write to the lock register
    output logic locked
);

    lock_st_e state_q;
    lock_st_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: if (key_wr)    state_d = LK_OPEN;
            LK_OPEN:   if (relock_wr) state_d = LK_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        locked = (state_q == LK_LOCKED);
    end

endmodule

// File: rtl/cfgctl_init_fsm.sv
module cfgctl_init_fsm
    import cfgctl_pkg::*;
#(
    parameter int DELAY = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_hi,   // program-reset control bit (1 = released)
    output logic init_hi    // modelled init response
);

    localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DELAY - 1);

    init_st_e       state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            IN_HIGH: begin
                if (!prog_hi) begin
                    state_d = IN_FALL;
                    cnt_d   = '0;
                end
            end
            IN_FALL: begin
                if (prog_hi)               state_d = IN_HIGH;
                else if (cnt_q == CNT_LAST) state_d = IN_LOW;
                else                        cnt_d   = cnt_q + 1'b1;
            end
            IN_LOW: begin
                if (prog_hi) begin
                    state_d = IN_RISE;
                    cnt_d   = '0;
                end
            end
            IN_RISE: begin
                if (!prog_hi)              state_d = IN_LOW;
                else if (cnt_q == CNT_LAST) state_d = IN_HIGH;
                else                        cnt_d   = cnt_q + 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IN_HIGH;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        init_hi = (state_q == IN_HIGH) || (state_q == IN_FALL);
    end

endmodule

// File: rtl/cfgctl_irq_unit.sv
module cfgctl_irq_unit
    import cfgctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] evt,
    input  logic          sts_wr,
    input  logic          mask_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] sts_q,
    output logic [DW-1:0] mask_q,
    output logic          irq
);

    logic [DW-1:0] clr_bits;
    logic [DW-1:0] set_bits;

    always_comb begin
        clr_bits = sts_wr ? wdata : '0;
        set_bits = evt & ISTS_IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q  <= '0;
            mask_q <= '1;
        end else begin
            sts_q <= (sts_q & ~clr_bits) | set_bits;
            if (mask_wr) mask_q <= wdata;
        end
    end

    always_comb begin
        irq = |(sts_q & ~mask_q);
    end

endmodule

// File: rtl/cfgctl_regfile.sv
module cfgctl_regfile
    import cfgctl_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int INIT_DELAY = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       evt_in,
    input  logic              dma_q_full,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_LOCK   = ADDR_W'(OFF_LOCK);
    localparam logic [ADDR_W-1:0] A_ISTS   = ADDR_W'(OFF_ISTS);
    localparam logic [ADDR_W-1:0] A_IMASK  = ADDR_W'(OFF_IMASK);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_UNLOCK = ADDR_W'(OFF_UNLOCK);
    localparam logic [ADDR_W-1:0] A_MISC   = ADDR_W'(OFF_MISC);

    logic          locked;
    logic          key_wr, relock_wr;
    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] misc_q;
    logic [DW-1:0] desc_q [DESC_N];
    logic [DW-1:0] sts_q, mask_q;
    logic          init_hi;
    logic          irq_w;

    always_comb begin
        key_wr    = bus_wr && (bus_addr == A_UNLOCK) && (bus_wdata == UNLOCK_KEY);
        relock_wr = bus_wr && (bus_addr == A_LOCK) && (bus_wdata != '0);
    end

    cfgctl_lock_fsm i_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_wr    (key_wr),
        .relock_wr (relock_wr),
        .locked    (locked)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
            misc_q <= '0;
        end else begin
            if (bus_wr && (bus_addr == A_CTRL) && !locked) ctrl_q <= bus_wdata & CTRL_KEEP;
            if (bus_wr && (bus_addr == A_MISC))            misc_q <= bus_wdata & MISC_KEEP;
        end
    end

    for (genvar g = 0; g < DESC_N; g++) begin : g_desc
        localparam logic [ADDR_W-1:0] A_D = ADDR_W'(OFF_DESC[g]);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           desc_q[g] <= '0;
            else if (bus_wr && (bus_addr == A_D)) desc_q[g] <= bus_wdata;
        end
    end

    cfgctl_init_fsm #(.DELAY(INIT_DELAY)) i_init (
        .clk     (clk),
        .rst_n   (rst_n),
        .prog_hi (ctrl_q[BIT_PROG]),
        .init_hi (init_hi)
    );

    cfgctl_irq_unit i_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_in),
        .sts_wr  (bus_wr && (bus_addr == A_ISTS)),
        .mask_wr (bus_wr && (bus_addr == A_IMASK)),
        .wdata   (bus_wdata),
        .sts_q   (sts_q),
        .mask_q  (mask_q),
        .irq     (irq_w)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:   bus_rdata = ctrl_q;
            A_LOCK:   bus_rdata = {31'd0, locked};
            A_ISTS:   bus_rdata = sts_q;
            A_IMASK:  bus_rdata = mask_q;
            A_STATUS: bus_rdata = {dma_q_full, 26'd0, init_hi, 4'd0};
            A_MISC:   bus_rdata = misc_q;
            default:  bus_rdata = '0;
        endcase
        for (int i = 0; i < DESC_N; i++) begin
            if (bus_addr == ADDR_W'(OFF_DESC[i])) bus_rdata = desc_q[i];
        end
    end

    always_comb begin
        irq = irq_w;
    end

endmodule

// File: rtl/cfgctl_regfile_chk.sv
module cfgctl_regfile_chk
    import cfgctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              locked,
    input logic [31:0]       ctrl_q,
    input logic              init_hi,
    input logic [31:0]       sts_q,
    input logic [31:0]       mask_q,
    input logic              irq
);

    AST_LOCKED_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(ctrl_q)); // R3

    AST_RELOCK_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_LOCK) && bus_wdata != 32'd0) |=> locked); // R4

    AST_INIT_FALL_AFTER_PROG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_hi) |-> !$past(ctrl_q[BIT_PROG])); // R6

    AST_INIT_RISE_AFTER_PROG_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_hi) |-> $past(ctrl_q[BIT_PROG])); // R6

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'(OFF_ISTS)) |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R9

    AST_IMPL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q & ~ISTS_IMPL) == 32'd0); // R9

    AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 32'hFFFF_FFFF) |-> !irq); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q == 32'd0) |-> !irq); // R10

endmodule

bind cfgctl_regfile cfgctl_regfile_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .locked    (locked),
    .ctrl_q    (ctrl_q),
    .init_hi   (init_hi),
    .sts_q     (sts_q),
    .mask_q    (mask_q),
    .irq       (irq)
);

// File: tb/test_cfgctl_regfile.sv
module test_cfgctl_regfile;

    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] evt_in = '0;
    logic        dma_q_full = 1'b0;
    logic        irq;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    cfgctl_regfile #(.ADDR_W(8), .INIT_DELAY(D)) i_cfgctl_regfile (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
        .dma_q_full(dma_q_full), .irq(irq)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0] m_ctrl, m_sts, m_mask, m_misc;
    logic [31:0] m_desc [4];
    bit          m_locked, m_init;
    int          m_wait;

    function automatic logic [31:0] mread(logic [7:0] a);
        case (a)
            8'h00: return m_ctrl;
            8'h04: return {31'd0, m_locked};
            8'h0C: return m_sts;
            8'h10: return m_mask;
            8'h14: return {dma_q_full, 26'd0, m_init, 4'd0};
            8'h18: return m_desc[0];
            8'h1C: return m_desc[1];
            8'h20: return m_desc[2];
            8'h24: return m_desc[3];
            8'h80: return m_misc;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tagof(logic [7:0] a);
        case (a)
            8'h00: return "R5";
            8'h04: return "R3";
            8'h0C: return "R9";
            8'h10: return "R10";
            8'h14: return "R6";
            8'h18, 8'h1C, 8'h20, 8'h24: return "R2";
            8'h80: return "R11";
            default: return "R12";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 32'h4000_0000; m_sts = 0; m_mask = 32'hFFFF_FFFF; m_misc = 0;
            foreach (m_desc[i]) m_desc[i] = 0;
            m_locked = 1; m_init = 1; m_wait = 0;
        end else begin
            bit prog;
            bit was_locked;
            prog = m_ctrl[30];
            was_locked = m_locked;
            if (m_init == prog) m_wait = 0;
            else begin
                m_wait++;
                if (m_wait == D + 1) begin m_init = prog; m_wait = 0; end
            end
            m_sts = (m_sts & ~((bus_wr && bus_addr == 8'h0C) ? bus_wdata : 32'd0))
                    | (evt_in & 32'hF8F7_F87F);
            if (bus_wr) begin
                case (bus_addr)
                    8'h00: if (!was_locked) m_ctrl = bus_wdata & 32'h4C00_0000;
                    8'h04: if (bus_wdata != 0) m_locked = 1;
                    8'h10: m_mask = bus_wdata;
                    8'h18: m_desc[0] = bus_wdata;
                    8'h1C: m_desc[1] = bus_wdata;
                    8'h20: m_desc[2] = bus_wdata;
                    8'h24: m_desc[3] = bus_wdata;
                    8'h34: if (bus_wdata == 32'h757B_DF0D) m_locked = 0;
                    8'h80: m_misc = bus_wdata & 32'h0000_0010;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R10", {31'd0, irq}, {31'd0, |(m_sts & ~m_mask)});
            chk(tagof(bus_addr), bus_rdata, mread(bus_addr));
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1;
            nchk++; nfail++;
            $display("FAIL R1: watchdog expired, actual %0d cycles expected < 50000", cyc);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_addr = a;
        @(posedge clk); #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1 reset values
        rd(8'h04, 32'h1, "R1");
        rd(8'h00, 32'h4000_0000, "R1");
        rd(8'h10, 32'hFFFF_FFFF, "R1");
        rd(8'h0C, 32'h0, "R1");
        rd(8'h14, 32'h10, "R1");
        chk("R1", {31'd0, irq}, 32'd0);

        // R3 locked control write ignored, wrong key, right key
        wr(8'h00, 32'h0000_0000);
        idle(D + 4);
        rd(8'h00, 32'h4000_0000, "R3");
        rd(8'h14, 32'h10, "R3");
        wr(8'h34, 32'h757B_DF0C);
        rd(8'h04, 32'h1, "R3");
        wr(8'h34, 32'h757B_DF0D);
        rd(8'h04, 32'h0, "R3");

        // R5 field masking
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 32'h4C00_0000, "R5");

        // R6 init falls D+1 edges after the write edge
        wr(8'h00, 32'h0C00_0000);
        bus_addr = 8'h14;
        for (int k = 1; k <= D + 1; k++) begin
            @(posedge clk); #1;
            chk("R6", {31'd0, bus_rdata[4]}, (k <= D) ? 32'd1 : 32'd0);
        end
        wr(8'h00, 32'h4C00_0000);
        bus_addr = 8'h14;
        for (int k = 1; k <= D + 1; k++) begin
            @(posedge clk); #1;
            chk("R6", {31'd0, bus_rdata[4]}, (k <= D) ? 32'd0 : 32'd1);
        end

        // R7 early return aborts the change
        wr(8'h00, 32'h0C00_0000);
        idle(3);
        wr(8'h00, 32'h4C00_0000);
        bus_addr = 8'h14;
        for (int k = 0; k < 2 * D; k++) begin
            @(posedge clk); #1;
            chk("R7", {31'd0, bus_rdata[4]}, 32'd1);
        end

        // R4 relock
        wr(8'h04, 32'h0);
        rd(8'h04, 32'h0, "R4");
        wr(8'h04, 32'h4);
        rd(8'h04, 32'h1, "R4");
        wr(8'h00, 32'h0400_0000);
        rd(8'h00, 32'h4C00_0000, "R4");

        // R8 queue full flag
        @(negedge clk); dma_q_full = 1;
        rd(8'h14, 32'h8000_0010, "R8");
        @(negedge clk); dma_q_full = 0;
        rd(8'h14, 32'h0000_0010, "R8");

        // R9 sticky status
        @(negedge clk); evt_in = 32'hFFFF_FFFF;
        @(negedge clk); evt_in = 0;
        rd(8'h0C, 32'hF8F7_F87F, "R9");
        chk("R10", {31'd0, irq}, 32'd0);
        wr(8'h10, ~(32'd1 << 13));
        @(posedge clk); #1;
        chk("R10", {31'd0, irq}, 32'd1);
        wr(8'h0C, 32'h0);
        rd(8'h0C, 32'hF8F7_F87F, "R9");
        wr(8'h0C, 32'd1 << 13);
        rd(8'h0C, 32'hF8F7_D87F, "R9");
        chk("R10", {31'd0, irq}, 32'd0);
        // set wins over clear on the same edge
        @(negedge clk);
        bus_wr = 1; bus_addr = 8'h0C; bus_wdata = 32'd1 << 2; evt_in = 32'd1 << 2;
        @(negedge clk);
        bus_wr = 0; evt_in = 0;
        rd(8'h0C, 32'hF8F7_D87F, "R9");
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, 32'h0, "R9");
        @(negedge clk); evt_in = 32'd1 << 12;
        @(negedge clk); evt_in = 0;
        wr(8'h10, 32'h0);
        @(posedge clk); #1;
        chk("R10", {31'd0, irq}, 32'd1);

        // R11 misc
        wr(8'h80, 32'hFFFF_FFFF);
        rd(8'h80, 32'h10, "R11");

        // R2 descriptor words
        wr(8'h18, 32'hA5A5_0001);
        wr(8'h1C, 32'h5A5A_0002);
        wr(8'h20, 32'h1234_5678);
        wr(8'h24, 32'hFEDC_BA98);
        rd(8'h18, 32'hA5A5_0001, "R2");
        rd(8'h1C, 32'h5A5A_0002, "R2");
        rd(8'h20, 32'h1234_5678, "R2");
        rd(8'h24, 32'hFEDC_BA98, "R2");

        // R12 unmapped offsets and unlock read
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h08, 32'h0, "R12");
        rd(8'h40, 32'h0, "R12");
        rd(8'h34, 32'h0, "R12");
        rd(8'h18, 32'hA5A5_0001, "R12");
        rd(8'h80, 32'h10, "R12");

        idle(4);
        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule